// File: doc/BRIEF.md
# Serial Register Access Port

This block is a four-wire serial slave that gives a host controller read and write access to a small bank of data locations. It wakes up in a passive default control mode. The host moves it into serial mode for good by driving the active-low select line low three times. Only a reset brings it back out. Once the port is in serial mode, every select-low period is one transaction. The host first sends an identity/direction byte, then a twelve-bit location number padded to two bytes, and then a stream of data bytes. Those data bytes fill or drain consecutive locations.

All pin inputs are resynchronised into the system clock domain, and edges are found there. For this reason the system clock must run at least four times faster than the serial clock. The port samples input bits on serial-clock rising edges. It changes output bits only after falling edges. The output pin's driver enable is a separate signal: it is high only while read data is being shifted out, so the serial output line can be shared by several slaves. A registered write strobe carries each committed word to the rest of the chip, and an internal location bank holds the stored data.

Top module: `spi_reg_port`

State machine: `ST_IDLE` waits for a select fall while in serial mode and then moves to `ST_HEAD`. `ST_HEAD` gathers 24 header bits. After the last header bit it goes to `ST_WRITE` (identity match, direction 0), `ST_READ` (identity match, direction 1) or `ST_SKIP` (no match). A select rise in any of these four states returns the machine to `ST_IDLE`.

## Requirements
- R1: After reset the port is outside serial mode, `spi_mode` and `miso_oe` are 0, no write strobe is issued, and every location reads back as zero.
- R2: The first three falling edges of `spi_sel_n` after reset only count toward mode entry. `spi_mode` rises on the third. Transactions are serviced from the fourth select fall onward. Serial mode is held until reset.
- R3: Header byte 0 holds a 7-bit identity in bits [7:1] and the direction in bit 0, where 1 means read and 0 means write. The identity must equal {6'b0, `strap_addr`}. With any other identity the transaction causes no write and `miso_oe` stays 0.
- R4: Header byte 1 bits [3:0] give location bits [11:8], and its bits [7:4] are ignored. Header byte 2 gives location bits [7:0]. All bytes travel MSB first, and bits are sampled on rising serial-clock edges.
- R5: A write commits after DATA_BYTES (default 2) full data bytes, the first byte received being the most significant. The commit stores the word and pulses `wr_stb` for one cycle with `wr_addr` and `wr_data`.
- R6: In a write burst, each further complete word goes to the next location number, which wraps at 12 bits.
- R7: A word left incomplete when select rises is discarded: no strobe is issued and the location is unchanged.
- R8: In a read, `miso_oe` stays 0 through the three header bytes. It rises after the 24th rising edge, and the word's MSB is presented before the next rising edge. Each later bit appears after a falling edge.
- R9: In a read burst, each further word comes from the next location number.
- R10: `miso_oe` returns to 0 once select rises and never rises during a write. `miso_data` is 0 whenever `miso_oe` is 0.
- R11: Locations at or beyond DEPTH (default 16) ignore writes and read as zero. The write strobe is still issued for them.
- R12: A reset taken while in serial mode returns the port outside serial mode, and the three-fall entry sequence is needed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| spi_sel_n | input | 1 | Active-low select / latch |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_mosi | input | 1 | Serial data from host |
| strap_addr | input | 1 | Identity strap, becomes identity LSB |
| miso_data | output | 1 | Serial data to host |
| miso_oe | output | 1 | Driver enable for the serial output pin |
| spi_mode | output | 1 | High once serial mode has been entered |
| wr_stb | output | 1 | One-cycle strobe per committed word |
| wr_addr | output | 12 | Location number of the committed word |
| wr_data | output | 16 | Committed word (DATA_BYTES*8 bits) |

## Verification
The bench sends a full write as the very first select pulse. A design that started servicing transactions at the first fall, or that needed only two pulses to enter serial mode, would issue a strobe there or report the mode too early.

It sends a header whose byte-1 upper nibble is not zero. It also sends identities that differ from the strap for both directions and for both strap values. A design that decoded those padding bits would land on the wrong location, and one that skipped the identity compare would write or drive the output line.

A one-and-a-half-word burst and a one-byte write test that partial words are discarded. A port that committed on each byte would corrupt the location. Burst reads cross a location boundary, so a design that reloaded on the wrong edge or forgot to advance the location would return shifted or repeated data. The bench also accesses an out-of-range location and takes a reset in mid-mode.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD,
        ST_WRITE,
        ST_READ,
        ST_SKIP
    } port_state_t;

    localparam int unsigned HDR_BITS = 24;
    localparam int unsigned LOC_W    = 12;
    localparam int unsigned ID_W     = 7;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic rise,
    output logic fall
);

    logic [STAGES-1:0] pipe;
    logic              prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= {STAGES{RST_VAL}};
            prev <= RST_VAL;
        end else begin
            pipe <= {pipe[STAGES-2:0], pin};
            prev <= pipe[STAGES-1];
        end
    end

    assign level = pipe[STAGES-1];
    assign rise  = level & ~prev;
    assign fall  = ~level & prev;

endmodule

// File: rtl/spi_mode_latch.sv
module spi_mode_latch #(
    parameter int unsigned ENTRY_PULSES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_fall,
    output logic spi_mode
);

    localparam int unsigned CW = $clog2(ENTRY_PULSES + 1);

    logic [CW-1:0] fall_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fall_cnt <= '0;
        end else if (!spi_mode && sel_fall) begin
            fall_cnt <= fall_cnt + 1'b1;
        end
    end

    assign spi_mode = (fall_cnt == CW'(ENTRY_PULSES));

endmodule

// File: rtl/spi_loc_bank.sv
module spi_loc_bank #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned DW    = 16,
    parameter int unsigned AW    = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int unsigned IW = $clog2(DEPTH);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we && (32'(waddr) < DEPTH)) begin
            mem[waddr[IW-1:0]] <= wdata;
        end
    end

    assign rdata = (32'(raddr) < DEPTH) ? mem[raddr[IW-1:0]] : '0;

endmodule

// File: rtl/spi_reg_port.sv
module spi_reg_port
    import spi_port_pkg::*;
#(
    parameter int unsigned DATA_BYTES = 2,
    parameter int unsigned DEPTH      = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       spi_sel_n,
    input  logic                       spi_sclk,
    input  logic                       spi_mosi,
    input  logic                       strap_addr,
    output logic                       miso_data,
    output logic                       miso_oe,
    output logic                       spi_mode,
    output logic                       wr_stb,
    output logic [LOC_W-1:0]           wr_addr,
    output logic [DATA_BYTES*8-1:0]    wr_data
);

    localparam int unsigned DW   = DATA_BYTES * 8;
    localparam int unsigned MAXB = (HDR_BITS > DW) ? HDR_BITS : DW;
    localparam int unsigned CNTW = $clog2(MAXB);
    localparam int unsigned NPIN = 3;
    localparam logic [NPIN-1:0] PIN_RST = 3'b001;  // select idles high

    // ---------------- pin synchronisers ----------------
    logic [NPIN-1:0] pin_raw, pin_lvl, pin_rise, pin_fall;
    assign pin_raw = {spi_mosi, spi_sclk, spi_sel_n};

    for (genvar g = 0; g < NPIN; g++) begin : g_sync
        spi_pin_sync #(.STAGES(2), .RST_VAL(PIN_RST[g])) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (pin_raw[g]),
            .level (pin_lvl[g]),
            .rise  (pin_rise[g]),
            .fall  (pin_fall[g])
        );
    end

    logic sel_rise, sel_fall, sclk_rise, sclk_fall, mosi_lvl;
    assign sel_rise  = pin_rise[0];
    assign sel_fall  = pin_fall[0];
    assign sclk_rise = pin_rise[1];
    assign sclk_fall = pin_fall[1];
    assign mosi_lvl  = pin_lvl[2];

    // ---------------- mode entry ----------------
    spi_mode_latch #(.ENTRY_PULSES(3)) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_fall (sel_fall),
        .spi_mode (spi_mode)
    );

    // ---------------- state and datapath ----------------
    port_state_t         state, nxt;
    logic [HDR_BITS-1:0] hdr, hdr_next;
    logic [CNTW-1:0]     bit_cnt;
    logic [LOC_W-1:0]    loc;
    logic [DW-1:0]       wshift, wnext, rshift, rdata;
    logic                rd_pend;
    logic                last_hdr_bit, id_match, is_read, commit;
    logic [LOC_W-1:0]    rd_loc;

    assign hdr_next     = {hdr[HDR_BITS-2:0], mosi_lvl};
    assign last_hdr_bit = (state == ST_HEAD) && sclk_rise &&
                          (bit_cnt == CNTW'(HDR_BITS - 1));
    assign id_match     = (hdr_next[HDR_BITS-1 -: ID_W] == {{(ID_W-1){1'b0}}, strap_addr});
    assign is_read      = hdr_next[HDR_BITS-ID_W-1];
    assign wnext        = {wshift[DW-2:0], mosi_lvl};
    assign commit       = (state == ST_WRITE) && sclk_rise && (bit_cnt == CNTW'(DW - 1));
    assign rd_loc       = (state == ST_HEAD) ? hdr_next[LOC_W-1:0] : loc;

    spi_loc_bank #(.DEPTH(DEPTH), .DW(DW), .AW(LOC_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (commit),
        .waddr (loc),
        .wdata (wnext),
        .raddr (rd_loc),
        .rdata (rdata)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (spi_mode && sel_fall) nxt = ST_HEAD;
            ST_HEAD: begin
                if (sel_rise)          nxt = ST_IDLE;
                else if (last_hdr_bit) nxt = !id_match ? ST_SKIP :
                                             (is_read ? ST_READ : ST_WRITE);
            end
            ST_WRITE, ST_READ, ST_SKIP: if (sel_rise) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr     <= '0;
            bit_cnt <= '0;
            loc     <= '0;
            wshift  <= '0;
            rshift  <= '0;
            rd_pend <= 1'b0;
            wr_stb  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_stb <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    bit_cnt <= '0;
                    rd_pend <= 1'b0;
                end
                ST_HEAD: if (sclk_rise) begin
                    hdr     <= hdr_next;
                    bit_cnt <= bit_cnt + 1'b1;
                    if (last_hdr_bit) begin
                        loc     <= hdr_next[LOC_W-1:0];
                        bit_cnt <= '0;
                        rshift  <= rdata;
                    end
                end
                ST_WRITE: if (sclk_rise) begin
                    wshift <= wnext;
                    if (commit) begin
                        bit_cnt <= '0;
                        wr_stb  <= 1'b1;
                        wr_addr <= loc;
                        wr_data <= wnext;
                        loc     <= loc + 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_READ: begin
                    if (sclk_rise) begin
                        rd_pend <= 1'b1;
                        if (bit_cnt == CNTW'(DW - 1)) begin
                            bit_cnt <= '0;
                            loc     <= loc + 1'b1;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end else if (sclk_fall && rd_pend) begin
                        rd_pend <= 1'b0;
                        rshift  <= (bit_cnt == '0) ? rdata : {rshift[DW-2:0], 1'b0};
                    end
                end
                ST_SKIP: ;
                default: ;
            endcase
        end
    end

    always_comb begin
        miso_oe   = (state == ST_READ);
        miso_data = miso_oe ? rshift[DW-1] : 1'b0;
    end

endmodule

// File: rtl/spi_reg_port_chk.sv
module spi_reg_port_chk (
    input logic clk,
    input logic rst_n,
    input logic spi_mode,
    input logic miso_oe,
    input logic miso_data,
    input logic wr_stb
);

    assert_mode_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_mode |=> spi_mode);

    assert_no_access_before_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_mode |-> (!miso_oe && !wr_stb));

    assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    assert_quiet_output_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !miso_oe |-> !miso_data);

    assert_no_drive_with_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> !miso_oe);

endmodule

bind spi_reg_port spi_reg_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_mode  (spi_mode),
    .miso_oe   (miso_oe),
    .miso_data (miso_data),
    .wr_stb    (wr_stb)
);

// File: tb/spi_reg_port_tb.sv
module spi_reg_port_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;   // system cycles per serial half-period

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sel_n = 1'b1, spi_sclk = 1'b0, spi_mosi = 1'b0, strap_addr = 1'b0;
    logic        miso_data, miso_oe, spi_mode, wr_stb;
    logic [11:0] wr_addr;
    logic [15:0] wr_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_reg_port u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sel_n(spi_sel_n), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .strap_addr(strap_addr), .miso_data(miso_data),
        .miso_oe(miso_oe), .spi_mode(spi_mode), .wr_stb(wr_stb),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    int n_chk = 0, n_fail = 0;
    int wr_cnt = 0;
    logic [11:0] last_addr;
    logic [15:0] last_data;

    always @(posedge clk) if (rst_n && wr_stb) begin
        wr_cnt++;
        last_addr = wr_addr;
        last_data = wr_data;
    end

    logic [7:0] tx [16];
    logic [7:0] rx [16];
    logic       rx_oe_any [16];
    logic       rx_oe_all [16];

    // {byte1, byte2, data}: location = {byte1[3:0], byte2}
    localparam logic [31:0] VEC [4] = '{
        {8'h00, 8'h00, 16'hA55A},
        {8'hF0, 8'h05, 16'h1234},
        {8'h00, 8'h0F, 16'h8001},
        {8'h00, 8'h07, 16'hFFFF}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input int nbytes);
        spi_sel_n = 1'b0;
        wait_cyc(HALF);
        for (int i = 0; i < nbytes; i++) begin
            rx_oe_any[i] = 1'b0;
            rx_oe_all[i] = 1'b1;
            for (int b = 7; b >= 0; b--) begin
                spi_mosi = tx[i][b];
                wait_cyc(HALF);
                rx[i][b]     = miso_data;
                rx_oe_any[i] = rx_oe_any[i] | miso_oe;
                rx_oe_all[i] = rx_oe_all[i] & miso_oe;
                spi_sclk = 1'b1;
                wait_cyc(HALF);
                spi_sclk = 1'b0;
            end
        end
        wait_cyc(HALF);
        spi_sel_n = 1'b1;
        wait_cyc(2*HALF);
    endtask

    task automatic set_hdr(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
        tx[0] = b0; tx[1] = b1; tx[2] = b2;
    endtask

    task automatic sel_pulse();
        spi_sel_n = 1'b0;
        wait_cyc(HALF);
        spi_sel_n = 1'b1;
        wait_cyc(HALF);
    endtask

    task automatic read_words(input logic [7:0] b0, input logic [11:0] loc, input int nw);
        set_hdr(b0, {4'h0, loc[11:8]}, loc[7:0]);
        for (int i = 0; i < 2*nw; i++) tx[3+i] = 8'h00;
        xfer(3 + 2*nw);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        int base;
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(4);
        // R1 reset state
        check("R1 mode", spi_mode, 0);
        check("R1 oe", miso_oe, 0);

        // R2: first select fall is a full write, must be ignored
        set_hdr(8'h00, 8'h00, 8'h03);
        tx[3] = 8'hDE; tx[4] = 8'hAD;
        xfer(5);
        check("R2 no write before mode", wr_cnt, 0);
        sel_pulse();
        check("R2 mode after two falls", spi_mode, 0);
        sel_pulse();
        check("R2 mode after three falls", spi_mode, 1);

        // R1: location reads zero after reset
        read_words(8'h01, 12'h003, 1);
        check("R1 reset contents", {rx[3], rx[4]}, 16'h0000);

        // R4/R5 table walk: write each vector then read back
        for (int v = 0; v < 4; v++) begin
            base = wr_cnt;
            set_hdr(8'h00, VEC[v][31:24], VEC[v][23:16]);
            tx[3] = VEC[v][15:8]; tx[4] = VEC[v][7:0];
            xfer(5);
            check("R5 strobe count", wr_cnt - base, 1);
            check("R4 write location", last_addr, {VEC[v][27:24], VEC[v][23:16]});
            check("R5 write data", last_data, VEC[v][15:0]);
            check("R10 oe after write", miso_oe, 0);
        end
        for (int v = 0; v < 4; v++) begin
            read_words(8'h01, {VEC[v][27:24], VEC[v][23:16]}, 1);
            check("R8 read data", {rx[3], rx[4]}, VEC[v][15:0]);
            check("R8 oe low in header", {rx_oe_any[0], rx_oe_any[1], rx_oe_any[2]}, 0);
            check("R8 oe high in data", {rx_oe_all[3], rx_oe_all[4]}, 2'b11);
            check("R10 oe after read", miso_oe, 0);
        end

        // R6 burst write 3 words from 0x009
        base = wr_cnt;
        set_hdr(8'h00, 8'h00, 8'h09);
        tx[3] = 8'h11; tx[4] = 8'h22; tx[5] = 8'h33; tx[6] = 8'h44; tx[7] = 8'h55; tx[8] = 8'h66;
        xfer(9);
        check("R6 burst strobes", wr_cnt - base, 3);
        check("R6 burst last location", last_addr, 12'h00B);
        check("R6 burst last data", last_data, 16'h5566);
        // R9 burst read
        read_words(8'h01, 12'h009, 3);
        check("R9 burst word0", {rx[3], rx[4]}, 16'h1122);
        check("R9 burst word1", {rx[5], rx[6]}, 16'h3344);
        check("R9 burst word2", {rx[7], rx[8]}, 16'h5566);

        // R7 partial words discarded
        base = wr_cnt;
        set_hdr(8'h00, 8'h00, 8'h00);
        tx[3] = 8'h77;
        xfer(4);
        check("R7 no strobe partial", wr_cnt - base, 0);
        set_hdr(8'h00, 8'h00, 8'h0C);
        tx[3] = 8'hC1; tx[4] = 8'hC2; tx[5] = 8'hC3;
        xfer(6);
        check("R7 one strobe for 1.5 words", wr_cnt - base, 1);
        read_words(8'h01, 12'h000, 1);
        check("R7 location unchanged", {rx[3], rx[4]}, 16'hA55A);
        read_words(8'h01, 12'h00D, 1);
        check("R7 next location unchanged", {rx[3], rx[4]}, 16'h0000);

        // R3 identity mismatch (strap 0, identity 1)
        base = wr_cnt;
        set_hdr(8'h02, 8'h00, 8'h00);
        tx[3] = 8'h99; tx[4] = 8'h99;
        xfer(5);
        check("R3 mismatch write ignored", wr_cnt - base, 0);
        read_words(8'h03, 12'h000, 1);
        check("R3 mismatch read not driven", rx_oe_any[3] | rx_oe_any[4], 0);
        strap_addr = 1'b1;
        read_words(8'h01, 12'h000, 1);
        check("R3 strap1 identity0 ignored", rx_oe_any[3], 0);
        read_words(8'h03, 12'h000, 1);
        check("R3 strap1 identity1 read", {rx[3], rx[4]}, 16'hA55A);
        set_hdr(8'h02, 8'h00, 8'h0E);
        tx[3] = 8'h5E; tx[4] = 8'hE5;
        xfer(5);
        check("R3 strap1 write location", last_addr, 12'h00E);
        strap_addr = 1'b0;

        // R11 out-of-range location
        base = wr_cnt;
        set_hdr(8'h00, 8'h01, 8'h00);
        tx[3] = 8'hAB; tx[4] = 8'hCD;
        xfer(5);
        check("R11 strobe still issued", wr_cnt - base, 1);
        read_words(8'h01, 12'h100, 1);
        check("R11 out of range reads zero", {rx[3], rx[4]}, 16'h0000);
        read_words(8'h01, 12'h000, 1);
        check("R11 no alias into bank", {rx[3], rx[4]}, 16'hA55A);

        // R12 reset leaves serial mode
        rst_n = 1'b0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(3);
        check("R12 mode cleared", spi_mode, 0);
        base = wr_cnt;
        set_hdr(8'h00, 8'h00, 8'h01);
        tx[3] = 8'h12; tx[4] = 8'h34;
        xfer(5);
        check("R12 write ignored after reset", wr_cnt - base, 0);
        sel_pulse();
        sel_pulse();
        check("R12 re-entry", spi_mode, 1);
        read_words(8'h01, 12'h000, 1);
        check("R1 contents cleared by reset", {rx[3], rx[4]}, 16'h0000);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule